// File: doc/BRIEF.md
# Sv39 Page Table Walker

This block turns a 39-bit virtual address into a 56-bit physical address by walking a three-level radix page table in memory, one 8-byte entry read at a time. A request carries the virtual address, the access kind (read, write, instruction fetch or atomic read-modify-write), the privilege level, the make-executable-readable and supervisor-user-access flags, an incoming global flag and the physical base of the root table. The walker accepts a request only while idle. It then issues one entry read per level on a simple request/response memory port and finishes with a single-cycle completion pulse.

A successful walk returns the physical address and a global indication. A failed walk returns one of five error kinds, together with the architectural exception cause derived from that kind and the access kind. Hardware updates of the accessed and dirty bits are not performed. When such an update would be needed, the walk reports it as an error. Translation caching, physical memory protection and the memory itself sit outside the block.

Top module: `ptw_sv39_walker`

## Requirements
- R1: An accepted walk starts at level 2. At level L the entry address is the current table base plus 8 times vaddr[12+9L+8 : 12+9L]. Exactly one single-cycle `mem_req_valid` pulse is issued per level, and the walker then waits for `mem_rsp_valid`.
- R2: An entry with V=1 and R=W=X=0 (bits V=0, R=1, W=2, X=3, U=4, G=5, A=6, D=7, PPN=bits 53:10) is a pointer. Above level 0 it makes the walk descend one level, with the new base equal to PPN shifted left by 12. A leaf found at level 0 yields the address {PPN, vaddr[11:0]}.
- R3: A leaf found at level 1 or 2 is a superpage. Its low 9·L PPN bits are replaced by the matching virtual page number bits before the 12-bit offset is appended.
- R4: A superpage leaf whose low 9·L PPN bits are not all zero fails with error code 4 (misaligned superpage).
- R5: An entry with V=0, or with W=1 and R=0, fails with error code 2 (bad entry). A pointer entry at level 0 also fails with error code 2.
- R6: A memory response with `mem_rsp_err` set fails the walk with error code 1 (memory access).
- R7: A leaf fails with error code 3 (no permission) in any of these cases:
  - A read finds neither R, nor X together with the MXR flag.
  - A write lacks W.
  - A fetch lacks X.
  - An atomic access lacks R or W.
  - Privilege 0 (user) meets U=0.
  - Privilege 1 or 3 meets U=1 when the access is a fetch or SUM is clear.
- R8: A leaf that passes the permission and alignment checks fails with error code 5 (update needed) when A=0, or when D=0 for a write or atomic access. The checks apply in this order: bad entry, permission, alignment, update.
- R9: `done_global` is the OR of `req_global` and the G bits of every entry read during the walk.
- R10: On success, `done_err` and `done_cause` are 0. A memory access error gives cause 5 for a read, 7 for a write or atomic access, and 1 for a fetch. Any other error gives cause 13 for a read, 15 for a write or atomic access, and 12 for a fetch. Access kind codes are read=0, write=1, fetch=2, atomic=3.
- R11: `req_ready` is high only when the walker is idle. A `req_valid` presented while busy is ignored. `done` is high for exactly one cycle per accepted request, starting one cycle after the final response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken when req_ready) |
| req_ready | output | 1 | Walker idle |
| req_vaddr | input | 39 | Virtual address |
| req_access | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 atomic |
| req_priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| req_mxr | input | 1 | Executable pages readable |
| req_sum | input | 1 | Supervisor may touch user pages |
| req_global | input | 1 | Incoming global flag |
| req_root_base | input | 56 | Physical base of the root table |
| mem_req_valid | output | 1 | Entry read request pulse |
| mem_req_addr | output | 56 | Entry address |
| mem_rsp_valid | input | 1 | Entry read response |
| mem_rsp_err | input | 1 | Response carries an access error |
| mem_rsp_data | input | 64 | Entry value |
| done | output | 1 | Result valid for one cycle |
| done_ok | output | 1 | Walk succeeded |
| done_paddr | output | 56 | Physical address (0 on failure) |
| done_global | output | 1 | Global indication |
| done_err | output | 3 | Error code (0 none) |
| done_cause | output | 4 | Exception cause (0 on success) |

## Verification
The walker is driven with translations that end at each of the three levels: a 4 KiB page, a 2 MiB page and a 1 GiB page, each using distinct virtual page number slices. Mixing up slices or the order of the levels therefore lands on an unmapped entry and shows up as a wrong result. Every error kind is provoked under several access kinds, so that the cause mapping for reads, writes, fetches and atomics is told apart, including that atomics never get load causes. Permission probes flip one input at a time: privilege, SUM, MXR, and the A and D bits. A request pulsed mid-walk confirms that a busy walker neither starts a second walk nor produces an extra completion.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W    = 39;
    localparam int PA_W    = 56;
    localparam int PPN_W   = 44;
    localparam int OFF_W   = 12;
    localparam int VPN_W   = 9;
    localparam int LEVELS  = 3;
    localparam int PTE_W   = 64;
    localparam int PTE_SH  = 3;
    localparam int LVL_W   = 2;
    localparam int CAUSE_W = 4;
    localparam int VPNS_W  = LEVELS * VPN_W;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RMW   = 2'd3
    } acc_e;

    localparam logic [1:0] PRV_USER = 2'd0;

    typedef enum logic [2:0] {
        WE_NONE   = 3'd0,
        WE_MEM    = 3'd1,
        WE_BADPTE = 3'd2,
        WE_PERM   = 3'd3,
        WE_ALIGN  = 3'd4,
        WE_UPDATE = 3'd5
    } werr_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } wstate_e;

    typedef struct packed {
        logic [9:0]       rsvd;
        logic [PPN_W-1:0] ppn;
        logic [1:0]       rsw;
        logic             d;
        logic             a;
        logic             g;
        logic             u;
        logic             x;
        logic             w;
        logic             r;
        logic             v;
    } pte_t;

    localparam logic [CAUSE_W-1:0] CS_FETCH_ACC = 4'd1;
    localparam logic [CAUSE_W-1:0] CS_LOAD_ACC  = 4'd5;
    localparam logic [CAUSE_W-1:0] CS_STAMO_ACC = 4'd7;
    localparam logic [CAUSE_W-1:0] CS_FETCH_PG  = 4'd12;
    localparam logic [CAUSE_W-1:0] CS_LOAD_PG   = 4'd13;
    localparam logic [CAUSE_W-1:0] CS_STAMO_PG  = 4'd15;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [PA_W-1:0]  base,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] level,
    output logic [PA_W-1:0]  pte_addr
);
    logic [VPN_W-1:0] slice [LEVELS];
    logic [VPN_W-1:0] sel;

    generate
        for (genvar l = 0; l < LEVELS; l++) begin : g_slice
            assign slice[l] = vaddr[OFF_W + l*VPN_W +: VPN_W];
        end
    endgenerate

    always_comb begin
        sel = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (level == LVL_W'(i)) sel = slice[i];
        end
    end

    assign pte_addr = base + PA_W'({sel, {PTE_SH{1'b0}}});
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
    import ptw_pkg::*;
(
    input  pte_t              pte,
    input  acc_e              acc,
    input  logic [1:0]        priv,
    input  logic              mxr,
    input  logic              sum,
    input  logic [LVL_W-1:0]  level,
    input  logic [VPNS_W-1:0] vpn,
    output logic              is_ptr,
    output werr_e             werr,
    output logic [PPN_W-1:0]  leaf_ppn
);
    logic [PPN_W-1:0] low_mask [LEVELS];
    logic [PPN_W-1:0] sel_mask;
    logic [PPN_W-1:0] vpn_ext;
    logic invalid, kind_ok, priv_ok, need_ad, is_store;
    logic unused_pte;

    generate
        for (genvar l = 0; l < LEVELS; l++) begin : g_mask
            localparam logic [PPN_W-1:0] M = (PPN_W'(1) << (l*VPN_W)) - PPN_W'(1);
            assign low_mask[l] = M;
        end
    endgenerate

    always_comb begin
        sel_mask = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (level == LVL_W'(i)) sel_mask = low_mask[i];
        end
    end

    assign unused_pte = ^{pte.rsvd, pte.rsw, pte.g};
    assign vpn_ext    = PPN_W'(vpn);
    assign invalid    = !pte.v || (pte.w && !pte.r);
    assign is_ptr     = !invalid && !pte.r && !pte.w && !pte.x;
    assign is_store   = (acc == ACC_WRITE) || (acc == ACC_RMW);

    always_comb begin
        unique case (acc)
            ACC_READ:  kind_ok = pte.r || (mxr && pte.x);
            ACC_WRITE: kind_ok = pte.w;
            ACC_FETCH: kind_ok = pte.x;
            default:   kind_ok = pte.r && pte.w;
        endcase
    end

    assign priv_ok  = (priv == PRV_USER) ? pte.u
                                         : (!pte.u || (sum && acc != ACC_FETCH));
    assign need_ad  = !pte.a || (is_store && !pte.d);
    assign leaf_ppn = (pte.ppn & ~sel_mask) | (vpn_ext & sel_mask);

    always_comb begin
        if (invalid)                          werr = WE_BADPTE;
        else if (is_ptr)                      werr = (level == '0) ? WE_BADPTE : WE_NONE;
        else if (!(kind_ok && priv_ok))       werr = WE_PERM;
        else if ((pte.ppn & sel_mask) != '0)  werr = WE_ALIGN;
        else if (need_ad)                     werr = WE_UPDATE;
        else                                  werr = WE_NONE;
    end
endmodule

// File: rtl/ptw_fault_map.sv
module ptw_fault_map
    import ptw_pkg::*;
(
    input  acc_e                acc,
    input  werr_e               werr,
    output logic [CAUSE_W-1:0]  cause
);
    always_comb begin
        if (werr == WE_NONE) begin
            cause = '0;
        end else if (werr == WE_MEM) begin
            unique case (acc)
                ACC_READ:  cause = CS_LOAD_ACC;
                ACC_FETCH: cause = CS_FETCH_ACC;
                default:   cause = CS_STAMO_ACC;
            endcase
        end else begin
            unique case (acc)
                ACC_READ:  cause = CS_LOAD_PG;
                ACC_FETCH: cause = CS_FETCH_PG;
                default:   cause = CS_STAMO_PG;
            endcase
        end
    end
endmodule

// File: rtl/ptw_sv39_walker.sv
module ptw_sv39_walker
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [1:0]         req_access,
    input  logic [1:0]         req_priv,
    input  logic               req_mxr,
    input  logic               req_sum,
    input  logic               req_global,
    input  logic [PA_W-1:0]    req_root_base,
    output logic               mem_req_valid,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic               mem_rsp_err,
    input  logic [PTE_W-1:0]   mem_rsp_data,
    output logic               done,
    output logic               done_ok,
    output logic [PA_W-1:0]    done_paddr,
    output logic               done_global,
    output logic [2:0]         done_err,
    output logic [CAUSE_W-1:0] done_cause
);
    wstate_e          st;
    logic [LVL_W-1:0] lvl;
    logic [PA_W-1:0]  base;
    logic [VA_W-1:0]  va_q;
    acc_e             acc_q;
    logic [1:0]       priv_q;
    logic             mxr_q, sum_q, g_acc;

    pte_t                pte;
    logic                ev_ptr;
    werr_e               ev_err, werr_now;
    logic [PPN_W-1:0]    leaf_ppn;
    logic [CAUSE_W-1:0]  cause_now;

    assign pte = pte_t'(mem_rsp_data);

    ptw_addr_gen u_addr (
        .base     (base),
        .vaddr    (va_q),
        .level    (lvl),
        .pte_addr (mem_req_addr)
    );

    ptw_pte_eval u_eval (
        .pte      (pte),
        .acc      (acc_q),
        .priv     (priv_q),
        .mxr      (mxr_q),
        .sum      (sum_q),
        .level    (lvl),
        .vpn      (va_q[VA_W-1:OFF_W]),
        .is_ptr   (ev_ptr),
        .werr     (ev_err),
        .leaf_ppn (leaf_ppn)
    );

    assign werr_now = mem_rsp_err ? WE_MEM : ev_err;

    ptw_fault_map u_fault (
        .acc   (acc_q),
        .werr  (werr_now),
        .cause (cause_now)
    );

    assign req_ready     = (st == ST_IDLE);
    assign mem_req_valid = (st == ST_ISSUE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            lvl         <= '0;
            base        <= '0;
            va_q        <= '0;
            acc_q       <= ACC_READ;
            priv_q      <= '0;
            mxr_q       <= 1'b0;
            sum_q       <= 1'b0;
            g_acc       <= 1'b0;
            done        <= 1'b0;
            done_ok     <= 1'b0;
            done_paddr  <= '0;
            done_global <= 1'b0;
            done_err    <= '0;
            done_cause  <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_vaddr;
                        acc_q  <= acc_e'(req_access);
                        priv_q <= req_priv;
                        mxr_q  <= req_mxr;
                        sum_q  <= req_sum;
                        g_acc  <= req_global;
                        base   <= req_root_base;
                        lvl    <= LVL_W'(LEVELS-1);
                        st     <= ST_ISSUE;
                    end
                end
                ST_ISSUE: st <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!mem_rsp_err && ev_err == WE_NONE && ev_ptr) begin
                            base  <= PA_W'({pte.ppn, {OFF_W{1'b0}}});
                            lvl   <= lvl - LVL_W'(1);
                            g_acc <= g_acc | pte.g;
                            st    <= ST_ISSUE;
                        end else begin
                            done        <= 1'b1;
                            done_ok     <= (werr_now == WE_NONE);
                            done_err    <= werr_now;
                            done_cause  <= cause_now;
                            done_global <= g_acc | (!mem_rsp_err & pte.g);
                            done_paddr  <= (werr_now == WE_NONE)
                                           ? PA_W'({leaf_ppn, va_q[OFF_W-1:0]}) : '0;
                            st          <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    p_accept_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> mem_req_valid && !req_ready);
    p_req_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_ok_clean_r10: assert property (@(posedge clk) disable iff (rst)
        done && done_ok |-> done_err == 3'd0 && done_cause == '0);
    p_mem_access_r10: assert property (@(posedge clk) disable iff (rst)
        done && done_err == WE_MEM |->
            done_cause == CS_LOAD_ACC || done_cause == CS_STAMO_ACC || done_cause == CS_FETCH_ACC);
    p_rmw_no_load_r10: assert property (@(posedge clk) disable iff (rst)
        done && acc_q == ACC_RMW |-> done_cause != CS_LOAD_ACC && done_cause != CS_LOAD_PG);
endmodule

// File: tb/ptw_sv39_walker_test.sv
module ptw_sv39_walker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [38:0] req_vaddr = '0;
    logic [1:0]  req_access = '0;
    logic [1:0]  req_priv = '0;
    logic        req_mxr = 1'b0, req_sum = 1'b0, req_global = 1'b0;
    logic [55:0] req_root_base = '0;
    logic        mem_req_valid;
    logic [55:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done, done_ok, done_global;
    logic [55:0] done_paddr;
    logic [2:0]  done_err;
    logic [3:0]  done_cause;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ptw_sv39_walker uut (.*);

    typedef struct {
        string       tag;
        logic        ok;
        logic [55:0] pa;
        logic [2:0]  err;
        logic [3:0]  cause;
        logic        g;
    } exp_t;
    exp_t exp_q[$];

    logic [63:0] mem [logic [55:0]];

    localparam logic [55:0] ROOT = 56'h8000_0000;
    localparam logic [55:0] L1T  = 56'h8000_1000;
    localparam logic [55:0] L0T  = 56'h8000_2000;
    localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08,
                           FU = 8'h10, FG = 8'h20, FA = 8'h40, FD = 8'h80;

    function automatic logic [63:0] mkpte(input logic [43:0] ppn, input logic [7:0] fl);
        return {10'b0, ppn, 2'b0, fl};
    endfunction

    function automatic logic [38:0] mkva(input logic [8:0] v2, input logic [8:0] v1,
                                         input logic [8:0] v0, input logic [11:0] off);
        return {v2, v1, v0, off};
    endfunction

    // memory model: fixed two-cycle latency, unmapped address answers with an error
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_valid) begin
                logic [55:0] a;
                a = mem_req_addr;
                repeat (2) @(negedge clk);
                mem_rsp_valid = 1'b1;
                if (mem.exists(a)) begin
                    mem_rsp_data = mem[a];
                    mem_rsp_err  = 1'b0;
                end else begin
                    mem_rsp_data = '0;
                    mem_rsp_err  = 1'b1;
                end
            end
        end
    end

    // monitor: compare each completion with the head of the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && done) begin
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R11 unexpected done: actual err=%0d expected no completion", done_err);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (done_ok !== e.ok || done_err !== e.err || done_cause !== e.cause ||
                        done_paddr !== e.pa || done_global !== e.g) begin
                        bad++;
                        $display("FAIL %s actual ok=%0d pa=%h err=%0d cause=%0d g=%0d expected ok=%0d pa=%h err=%0d cause=%0d g=%0d",
                                 e.tag, done_ok, done_paddr, done_err, done_cause, done_global,
                                 e.ok, e.pa, e.err, e.cause, e.g);
                    end
                end
            end
        end
    end

    task automatic check(input string tag, input logic act, input logic expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic walk(input logic [38:0] va, input logic [1:0] acc, input logic [1:0] pv,
                        input logic mxr, input logic sum, input logic g, input string tag,
                        input logic eok, input logic [55:0] epa, input logic [2:0] eerr,
                        input logic [3:0] ecause, input logic eg);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_vaddr = va; req_access = acc; req_priv = pv;
        req_mxr = mxr; req_sum = sum; req_global = g; req_root_base = ROOT;
        req_valid = 1'b1;
        e.tag = tag; e.ok = eok; e.pa = epa; e.err = eerr; e.cause = ecause; e.g = eg;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic settle();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // tables
        mem[ROOT + 1*8]     = mkpte(44'h80001, FV);
        mem[ROOT + 5*8]     = mkpte(44'h80001, FV | FG);
        mem[ROOT + 2*8]     = mkpte(44'h100000, FV | FR | FW | FA | FD);
        mem[ROOT + 3*8]     = 64'h0;
        mem[ROOT + 4*8]     = mkpte(44'h1, FV | FW | FA | FD);
        mem[L1T + 2*8]      = mkpte(44'h80002, FV);
        mem[L1T + 5*8]      = mkpte(44'h40000, FV | FR | FX | FA | FG);
        mem[L1T + 6*8]      = mkpte(44'h40001, FV | FR | FA);
        mem[L0T + 3*8]      = mkpte(44'h12345, FV | FR | FW | FA | FD);
        mem[L0T + 4*8]      = mkpte(44'h80003, FV);
        mem[L0T + 5*8]      = mkpte(44'h22222, FV | FR | FW | FX | FU | FA | FD);
        mem[L0T + 6*8]      = mkpte(44'h33333, FV | FX | FA);
        mem[L0T + 7*8]      = mkpte(44'h44444, FV | FR | FW | FA);
        mem[L0T + 8*8]      = mkpte(44'h55555, FV | FR | FW);
        mem[L0T + 9*8]      = mkpte(44'h66666, FV | FR | FA | FD);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset ready", req_ready, 1'b1);
        check("R11 reset done", done, 1'b0);
        check("R1 reset mem_req_valid", mem_req_valid, 1'b0);

        // R1 R2: three-level walk to a 4 KiB page
        walk(mkva(1, 2, 3, 12'hABC), 2'd0, 2'd1, 0, 0, 0, "R1 R2 4k read", 1, 56'h12345ABC, 3'd0, 4'd0, 0);
        settle();
        // R3: 2 MiB and 1 GiB pages
        walk(mkva(1, 5, 9'h1F, 12'h123), 2'd2, 2'd1, 0, 0, 0, "R3 2M fetch", 1, 56'h4001F123, 3'd0, 4'd0, 1);
        walk(mkva(2, 9'h1AB, 9'h0CD, 12'h007), 2'd1, 2'd1, 0, 0, 0, "R3 1G write", 1, 56'h1356CD007, 3'd0, 4'd0, 0);
        // R4
        walk(mkva(1, 6, 0, 0), 2'd0, 2'd1, 0, 0, 0, "R4 misaligned read", 0, 56'h0, 3'd4, 4'd13, 0);
        // R5
        walk(mkva(3, 0, 0, 0), 2'd1, 2'd1, 0, 0, 0, "R5 V=0 write", 0, 56'h0, 3'd2, 4'd15, 0);
        walk(mkva(4, 0, 0, 0), 2'd2, 2'd1, 0, 0, 0, "R5 W without R fetch", 0, 56'h0, 3'd2, 4'd12, 0);
        walk(mkva(1, 2, 4, 0), 2'd3, 2'd1, 0, 0, 0, "R5 R10 level0 pointer atomic", 0, 56'h0, 3'd2, 4'd15, 0);
        // R6 R10: memory errors per access kind
        walk(mkva(7, 0, 0, 0), 2'd0, 2'd1, 0, 0, 0, "R6 R10 mem read", 0, 56'h0, 3'd1, 4'd5, 0);
        walk(mkva(7, 0, 0, 0), 2'd2, 2'd1, 0, 0, 0, "R6 R10 mem fetch", 0, 56'h0, 3'd1, 4'd1, 0);
        walk(mkva(7, 0, 0, 0), 2'd3, 2'd1, 0, 0, 0, "R6 R10 mem atomic", 0, 56'h0, 3'd1, 4'd7, 0);
        walk(mkva(1, 7, 0, 0), 2'd1, 2'd1, 0, 0, 0, "R6 R10 mem write level1", 0, 56'h0, 3'd1, 4'd7, 0);
        // R7: privilege, SUM, MXR, kind
        walk(mkva(1, 2, 3, 0), 2'd0, 2'd0, 0, 0, 0, "R7 user on supervisor page", 0, 56'h0, 3'd3, 4'd13, 0);
        walk(mkva(1, 2, 5, 12'h010), 2'd0, 2'd1, 0, 0, 0, "R7 user page no SUM", 0, 56'h0, 3'd3, 4'd13, 0);
        walk(mkva(1, 2, 5, 12'h010), 2'd0, 2'd1, 0, 1, 0, "R7 user page with SUM", 1, 56'h22222010, 3'd0, 4'd0, 0);
        walk(mkva(1, 2, 5, 12'h010), 2'd2, 2'd1, 0, 1, 0, "R7 fetch user page SUM", 0, 56'h0, 3'd3, 4'd12, 0);
        walk(mkva(1, 2, 5, 12'h010), 2'd0, 2'd0, 0, 0, 0, "R7 user read user page", 1, 56'h22222010, 3'd0, 4'd0, 0);
        walk(mkva(1, 2, 6, 12'h020), 2'd0, 2'd1, 0, 0, 0, "R7 exec-only read no MXR", 0, 56'h0, 3'd3, 4'd13, 0);
        walk(mkva(1, 2, 6, 12'h020), 2'd0, 2'd1, 1, 0, 0, "R7 exec-only read MXR", 1, 56'h33333020, 3'd0, 4'd0, 0);
        walk(mkva(1, 2, 9, 0), 2'd1, 2'd1, 0, 0, 0, "R7 write read-only", 0, 56'h0, 3'd3, 4'd15, 0);
        walk(mkva(1, 2, 9, 0), 2'd3, 2'd1, 0, 0, 0, "R7 R10 atomic read-only", 0, 56'h0, 3'd3, 4'd15, 0);
        // R8
        walk(mkva(1, 2, 7, 0), 2'd0, 2'd1, 0, 0, 0, "R8 D=0 read ok", 1, 56'h44444000, 3'd0, 4'd0, 0);
        walk(mkva(1, 2, 7, 0), 2'd1, 2'd1, 0, 0, 0, "R8 D=0 write", 0, 56'h0, 3'd5, 4'd15, 0);
        walk(mkva(1, 2, 8, 0), 2'd0, 2'd1, 0, 0, 0, "R8 A=0 read", 0, 56'h0, 3'd5, 4'd13, 0);
        // R9
        walk(mkva(5, 2, 3, 12'hABC), 2'd0, 2'd1, 0, 0, 0, "R9 G on pointer", 1, 56'h12345ABC, 3'd0, 4'd0, 1);
        walk(mkva(1, 2, 3, 12'hABC), 2'd0, 2'd1, 0, 0, 1, "R9 incoming global", 1, 56'h12345ABC, 3'd0, 4'd0, 1);
        settle();

        // R11: request while busy is ignored
        walk(mkva(1, 2, 3, 12'h001), 2'd0, 2'd1, 0, 0, 0, "R11 walk under busy pulse", 1, 56'h12345001, 3'd0, 4'd0, 0);
        @(negedge clk);
        check("R11 ready low while busy", req_ready, 1'b0);
        req_vaddr = mkva(7, 0, 0, 0); req_access = 2'd0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        settle();
        repeat (20) @(negedge clk);
        check("R11 ready after walks", req_ready, 1'b1);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule